// File: doc/BRIEF.md
# Flash cache program engine

This block is the device side of a two-stage page program operation for a byte-wide flash interface, written as synthesizable logic. A host writes commands, addresses and data over an 8-bit bus. Each write cycle is marked as a command or an address by a latch strobe, and a cycle with neither strobe carries data. The block keeps two page-sized buffers. The cache buffer receives incoming bytes. The data buffer holds the page that is being programmed. Programming of the cell array is not modelled: a countdown stands in for the programming time. A completion pulse reports the row of the finished page and the XOR of its bytes.

A cache program command hands the loaded page to the data buffer. The host can then load the next page while the previous one is still programming. A normal program command keeps the block busy until its page is finished. A status command places a status byte on the output. The byte has separate cache-ready and internal-ready flags, a pass/fail flag for the previous page and one for the current page. A test input forces the program of one chosen row to fail.

Top module: `nand_cache_prog`

## Requirements
- R1: After reset `rdy` is 1, `io_out` is 0 and `prog_done` is 0. A status command issued at that point reads 0x60.
- R2: Command 0x80 clears every byte of the cache to 0xFF. Four address cycles follow in this order: column low, column high, row low, row high. Each data cycle then writes one byte at the current column and advances the column by one. Columns at or above the page size are not stored. When a page finishes, `prog_done` pulses and `prog_row` and `prog_sum` (the XOR of all page bytes) describe that page.
- R3: Command 0x85, accepted only after a load address is complete, takes two column cycles (low, then high). It moves the write column and leaves the bytes already loaded in place.
- R4: Command 0x15 with no program running holds `rdy` low for exactly XFER_CYC cycles. The page then programs for PROG_CYC cycles and ends with a `prog_done` pulse one cycle long.
- R5: Command 0x15 issued while a program is running keeps `rdy` low until that program ends, and then for XFER_CYC more cycles.
- R6: Command 0x10 drops `rdy` in the cycle after the command. `rdy` stays low until the cycle in which that page's `prog_done` pulses. With no program running, that is XFER_CYC+PROG_CYC cycles.
- R7: Status bit 6 is 1 when no cache transfer is pending. Bit 5 is 1 when no transfer is pending and no page is programming. Bits 7, 4, 3 and 2 read 0.
- R8: Status bit 0 is 1 if the last finished page failed. It is cleared when a new page starts and updated in the cycle of that page's `prog_done`. Bit 1 takes the value of bit 0 when a new page moves into the data buffer. A page fails when `fail_en` is 1 and `fail_row` equals its row.
- R9: While `rdy` is 0, every command except 0x70 and every address or data cycle is ignored. The cache contents and the status display stay as they were.
- R10: A command 0x15 is rejected while a page is programming if its row is in a different block from that page, where block = row >> BLK_SHIFT. After a rejected command `rdy` stays 1 and no extra page is programmed.
- R11: `io_out` shows the status byte from the cycle after a 0x70 command until the next accepted command. At all other times it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write cycle valid |
| cmd_latch | input | 1 | Cycle carries a command byte (wins over addr_latch) |
| addr_latch | input | 1 | Cycle carries an address byte |
| io_in | input | 8 | Bus byte from host |
| io_out | output | 8 | Status byte after 0x70, otherwise 0 |
| rdy | output | 1 | 1 = ready, 0 = busy |
| prog_done | output | 1 | One-cycle pulse when a page finishes programming |
| prog_row | output | 16 | Row of the page that is programming or just finished |
| prog_sum | output | 8 | XOR of all bytes of that page |
| fail_en | input | 1 | Enables forced program failure |
| fail_row | input | 16 | Row whose program is forced to fail |

## Verification
The assertions rely on the host never raising both latch strobes in one cycle with a meaning other than a command. They also rely on `fail_en` and `fail_row` staying stable while a page finishes, and on XFER_CYC and PROG_CYC being at least one. The stimulus changes the failure row only at the start, before any program runs. It raises one strobe at a time, and it issues status and load commands only at the points the requirements allow. The busy-time cases deliberately send 0x80 and data bytes while a transfer is pending, to show that they leave the cache and the status display untouched.

// File: rtl/nand_cp_pkg.sv
package nand_cp_pkg;
    localparam int ROW_W = 16;
    localparam int COL_W = 16;

    localparam logic [7:0] OP_LOAD    = 8'h80;
    localparam logic [7:0] OP_COLMOVE = 8'h85;
    localparam logic [7:0] OP_CACHE   = 8'h15;
    localparam logic [7:0] OP_PAGE    = 8'h10;
    localparam logic [7:0] OP_STATUS  = 8'h70;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_ADDR = 2'd1,
        BUS_DATA = 2'd2,
        BUS_COL  = 2'd3
    } bus_st_e;
endpackage

// File: rtl/nand_cp_bus.sv
module nand_cp_bus
    import nand_cp_pkg::*;
#(
    parameter int PAGE_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    cmd_latch,
    input  logic                    addr_latch,
    input  logic [7:0]              io_in,
    input  logic                    ready_i,
    input  logic [7:0]              status_i,
    output logic [7:0]              io_out,
    output logic                    req_cache_o,
    output logic                    req_page_o,
    output logic [ROW_W-1:0]        row_o,
    output logic [PAGE_BYTES*8-1:0] cache_o
);
    localparam int IDX_W = $clog2(PAGE_BYTES);
    localparam logic [COL_W-1:0] PAGE_L = COL_W'(PAGE_BYTES);

    typedef struct packed {
        bus_st_e                          st;
        logic [1:0]                       acnt;
        logic [COL_W-1:0]                 col;
        logic [ROW_W-1:0]                 row;
        logic                             show;
        logic [PAGE_BYTES-1:0][7:0]       cache;
    } bus_s;

    bus_s d, q;
    logic cmd_ok;

    always_comb begin
        d           = q;
        req_cache_o = 1'b0;
        req_page_o  = 1'b0;
        cmd_ok      = wr_en && cmd_latch && (ready_i || io_in == OP_STATUS);
        if (cmd_ok) begin
            d.show = (io_in == OP_STATUS);
            case (io_in)
                OP_LOAD: begin
                    d.st    = BUS_ADDR;
                    d.acnt  = '0;
                    d.col   = '0;
                    d.cache = '1;
                end
                OP_COLMOVE: begin
                    d.acnt = '0;
                    d.st   = (q.st == BUS_DATA) ? BUS_COL : BUS_IDLE;
                end
                OP_CACHE: begin
                    d.st        = BUS_IDLE;
                    req_cache_o = (q.st == BUS_DATA);
                end
                OP_PAGE: begin
                    d.st       = BUS_IDLE;
                    req_page_o = (q.st == BUS_DATA);
                end
                default: d.st = BUS_IDLE;
            endcase
        end else if (wr_en && addr_latch && !cmd_latch && ready_i) begin
            if (q.st == BUS_ADDR) begin
                case (q.acnt)
                    2'd0: d.col[7:0]  = io_in;
                    2'd1: d.col[15:8] = io_in;
                    2'd2: d.row[7:0]  = io_in;
                    default: begin
                        d.row[15:8] = io_in;
                        d.st        = BUS_DATA;
                    end
                endcase
                d.acnt = q.acnt + 2'd1;
            end else if (q.st == BUS_COL) begin
                if (q.acnt == 2'd0) begin
                    d.col[7:0] = io_in;
                end else begin
                    d.col[15:8] = io_in;
                    d.st        = BUS_DATA;
                end
                d.acnt = q.acnt + 2'd1;
            end
        end else if (wr_en && !cmd_latch && !addr_latch && ready_i && q.st == BUS_DATA) begin
            if (q.col < PAGE_L) begin
                d.cache[q.col[IDX_W-1:0]] = io_in;
            end
            d.col = q.col + COL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= BUS_IDLE;
            q.cache <= '1;
        end else begin
            q <= d;
        end
    end

    assign io_out  = q.show ? status_i : 8'h00;
    assign row_o   = q.row;
    assign cache_o = q.cache;

    // R9: nothing reaches the cache while the device is busy
    assert_frozen_cache_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> $stable(q.cache));
endmodule

// File: rtl/nand_cp_fold.sv
module nand_cp_fold #(
    parameter int PAGE_BYTES = 16
) (
    input  logic [PAGE_BYTES*8-1:0] page_i,
    output logic [7:0]              sum_o
);
    always_comb begin
        sum_o = '0;
        for (int i = 0; i < PAGE_BYTES; i++) begin
            sum_o = sum_o ^ page_i[i*8 +: 8];
        end
    end
endmodule

// File: rtl/nand_cp_core.sv
module nand_cp_core
    import nand_cp_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int XFER_CYC   = 3,
    parameter int PROG_CYC   = 60,
    parameter int BLK_SHIFT  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_cache_i,
    input  logic                    req_page_i,
    input  logic [ROW_W-1:0]        row_i,
    input  logic [PAGE_BYTES*8-1:0] cache_i,
    input  logic                    fail_en,
    input  logic [ROW_W-1:0]        fail_row,
    output logic                    ready_o,
    output logic [7:0]              status_o,
    output logic                    done_o,
    output logic [ROW_W-1:0]        drow_o,
    output logic [PAGE_BYTES*8-1:0] data_o
);
    localparam int CNT_MAX = (XFER_CYC > PROG_CYC) ? XFER_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] XFER_L = CNT_W'(XFER_CYC);
    localparam logic [CNT_W-1:0] PROG_L = CNT_W'(PROG_CYC);
    localparam logic [CNT_W-1:0] ONE_L  = CNT_W'(1);

    typedef struct packed {
        logic                       pend;
        logic [CNT_W-1:0]           xcnt;
        logic                       busy;
        logic [CNT_W-1:0]           pcnt;
        logic                       hold;
        logic [ROW_W-1:0]           prow;
        logic [ROW_W-1:0]           drow;
        logic [PAGE_BYTES*8-1:0]    data;
        logic                       prev_fail;
        logic                       cur_fail;
        logic                       done;
    } core_s;

    core_s d, q;
    logic  other_blk;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        other_blk = (row_i >> BLK_SHIFT) != (q.drow >> BLK_SHIFT);
        if (q.busy) begin
            if (q.pcnt == ONE_L) begin
                d.busy     = 1'b0;
                d.done     = 1'b1;
                d.cur_fail = fail_en && (fail_row == q.drow);
                if (q.hold && !q.pend) begin
                    d.hold = 1'b0;
                end
            end else begin
                d.pcnt = q.pcnt - ONE_L;
            end
        end else if (q.pend) begin
            if (q.xcnt == ONE_L) begin
                d.pend      = 1'b0;
                d.busy      = 1'b1;
                d.pcnt      = PROG_L;
                d.data      = cache_i;
                d.drow      = q.prow;
                d.prev_fail = q.cur_fail;
                d.cur_fail  = 1'b0;
            end else begin
                d.xcnt = q.xcnt - ONE_L;
            end
        end
        if ((req_cache_i && !(q.busy && other_blk)) || req_page_i) begin
            d.pend = 1'b1;
            d.xcnt = XFER_L;
            d.prow = row_i;
            d.hold = req_page_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ready_o  = !q.pend && !q.hold;
    assign status_o = {1'b0, !q.pend, !q.pend && !q.busy, 3'b000, q.prev_fail, q.cur_fail};
    assign done_o   = q.done;
    assign drow_o   = q.drow;
    assign data_o   = q.data;

    // R4: completion is a single-cycle pulse
    assert_done_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    // R4: a pending transfer with a free data buffer always moves forward
    assert_xfer_progress_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && !q.busy) |=> (!q.pend || q.xcnt < $past(q.xcnt)));
    // R5: the transfer waits while the data buffer is programming
    assert_wait_for_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && q.busy) |=> q.pend);
    // R8: the current-page fail flag only rises together with completion
    assert_fail_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> q.done);
endmodule

// File: rtl/nand_cache_prog.sv
module nand_cache_prog
    import nand_cp_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int XFER_CYC   = 3,
    parameter int PROG_CYC   = 60,
    parameter int BLK_SHIFT  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        cmd_latch,
    input  logic        addr_latch,
    input  logic [7:0]  io_in,
    output logic [7:0]  io_out,
    output logic        rdy,
    output logic        prog_done,
    output logic [15:0] prog_row,
    output logic [7:0]  prog_sum,
    input  logic        fail_en,
    input  logic [15:0] fail_row
);
    logic                    ready_w;
    logic [7:0]              status_w;
    logic                    req_cache_w;
    logic                    req_page_w;
    logic [ROW_W-1:0]        row_w;
    logic [PAGE_BYTES*8-1:0] cache_w;
    logic [PAGE_BYTES*8-1:0] data_w;

    nand_cp_bus #(.PAGE_BYTES(PAGE_BYTES)) i_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .cmd_latch   (cmd_latch),
        .addr_latch  (addr_latch),
        .io_in       (io_in),
        .ready_i     (ready_w),
        .status_i    (status_w),
        .io_out      (io_out),
        .req_cache_o (req_cache_w),
        .req_page_o  (req_page_w),
        .row_o       (row_w),
        .cache_o     (cache_w)
    );

    nand_cp_core #(
        .PAGE_BYTES (PAGE_BYTES),
        .XFER_CYC   (XFER_CYC),
        .PROG_CYC   (PROG_CYC),
        .BLK_SHIFT  (BLK_SHIFT)
    ) i_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_cache_i (req_cache_w),
        .req_page_i  (req_page_w),
        .row_i       (row_w),
        .cache_i     (cache_w),
        .fail_en     (fail_en),
        .fail_row    (fail_row),
        .ready_o     (ready_w),
        .status_o    (status_w),
        .done_o      (prog_done),
        .drow_o      (prog_row),
        .data_o      (data_w)
    );

    nand_cp_fold #(.PAGE_BYTES(PAGE_BYTES)) i_fold (
        .page_i (data_w),
        .sum_o  (prog_sum)
    );

    assign rdy = ready_w;
endmodule

// File: tb/test_nand_cache_prog.sv
module test_nand_cache_prog;
    localparam int PG = 16;
    localparam int XF = 3;
    localparam int PR = 60;
    localparam int BS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, cmd_latch = 1'b0, addr_latch = 1'b0;
    logic [7:0]  io_in = 8'h00;
    logic [7:0]  io_out;
    logic        rdy, prog_done;
    logic [15:0] prog_row;
    logic [7:0]  prog_sum;
    logic        fail_en = 1'b0;
    logic [15:0] fail_row = 16'h0;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    nand_cache_prog #(.PAGE_BYTES(PG), .XFER_CYC(XF), .PROG_CYC(PR), .BLK_SHIFT(BS)) i_nand_cache_prog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_latch(cmd_latch), .addr_latch(addr_latch),
        .io_in(io_in), .io_out(io_out), .rdy(rdy), .prog_done(prog_done), .prog_row(prog_row),
        .prog_sum(prog_sum), .fail_en(fail_en), .fail_row(fail_row));

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_phase = 0;          // 0 idle, 1 address, 2 data, 3 column move
    int         m_acnt = 0;
    logic [15:0] m_col = 0, m_row = 0, m_drow = 0, m_prow = 0;
    logic [7:0] m_cache[PG];
    logic [7:0] m_data[PG];
    bit         m_show = 0, m_pend = 0, m_hold = 0, m_prev = 0, m_cur = 0, m_done = 0;
    int         m_wait = 0, m_left = 0;
    bit         was_busy, was_pend, rdy_now;

    initial begin
        for (int i = 0; i < PG; i++) begin
            m_cache[i] = 8'hFF;
            m_data[i]  = 8'h00;
        end
    end

    function automatic logic [7:0] model_sum();
        logic [7:0] s = 8'h00;
        for (int i = 0; i < PG; i++) s = s ^ m_data[i];
        return s;
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            was_busy = (m_left > 0);
            was_pend = m_pend;
            rdy_now  = !m_pend && !m_hold;
            m_done   = 0;
            if (was_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_done = 1;
                    m_cur  = fail_en && (fail_row == m_drow);
                    if (m_hold && !was_pend) m_hold = 0;
                end
            end else if (was_pend) begin
                m_wait--;
                if (m_wait == 0) begin
                    for (int i = 0; i < PG; i++) m_data[i] = m_cache[i];
                    m_drow = m_prow;
                    m_pend = 0;
                    m_left = PR;
                    m_prev = m_cur;
                    m_cur  = 0;
                end
            end
            if (wr_en && cmd_latch) begin
                if (rdy_now || io_in == 8'h70) begin
                    m_show = (io_in == 8'h70);
                    if (io_in == 8'h80) begin
                        m_phase = 1; m_acnt = 0; m_col = 0;
                        for (int i = 0; i < PG; i++) m_cache[i] = 8'hFF;
                    end else if (io_in == 8'h85) begin
                        m_acnt = 0;
                        m_phase = (m_phase == 2) ? 3 : 0;
                    end else if (io_in == 8'h15 || io_in == 8'h10) begin
                        if (m_phase == 2 && (io_in == 8'h10 || !(was_busy && (m_row >> BS) != (m_drow >> BS)))) begin
                            m_pend = 1; m_wait = XF; m_prow = m_row; m_hold = (io_in == 8'h10);
                        end
                        m_phase = 0;
                    end else begin
                        m_phase = 0;
                    end
                end
            end else if (wr_en && addr_latch && rdy_now) begin
                if (m_phase == 1) begin
                    if (m_acnt == 0) m_col[7:0] = io_in;
                    else if (m_acnt == 1) m_col[15:8] = io_in;
                    else if (m_acnt == 2) m_row[7:0] = io_in;
                    else begin m_row[15:8] = io_in; m_phase = 2; end
                    m_acnt++;
                end else if (m_phase == 3) begin
                    if (m_acnt == 0) m_col[7:0] = io_in;
                    else begin m_col[15:8] = io_in; m_phase = 2; end
                    m_acnt++;
                end
            end else if (wr_en && rdy_now && m_phase == 2) begin
                if (m_col < PG) m_cache[m_col] = io_in;
                m_col = m_col + 16'd1;
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(rdy == (!m_pend && !m_hold), "model rdy R4", rdy, !m_pend && !m_hold);
            chk(io_out == (m_show ? {1'b0, !m_pend, !m_pend && m_left == 0, 3'b000, m_prev, m_cur} : 8'h00),
                "model io_out R7", io_out,
                m_show ? {1'b0, !m_pend, !m_pend && m_left == 0, 3'b000, m_prev, m_cur} : 8'h00);
            chk(prog_done == m_done, "model prog_done R4", prog_done, m_done);
            if (m_done) begin
                chk(prog_row == m_drow, "model prog_row R2", prog_row, m_drow);
                chk(prog_sum == model_sum(), "model prog_sum R2", prog_sum, model_sum());
            end
        end
    end

    // ---------------- stimulus ----------------
    logic [7:0] pg[PG];

    task automatic put(input bit c, input bit a, input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; cmd_latch = c; addr_latch = a; io_in = b;
    endtask

    task automatic rest();
        @(negedge clk);
        wr_en = 1'b0; cmd_latch = 1'b0; addr_latch = 1'b0;
    endtask

    task automatic load(input logic [15:0] row, input logic [15:0] col, input int n, input logic [7:0] seed);
        logic [15:0] c = col;
        for (int i = 0; i < PG; i++) pg[i] = 8'hFF;
        put(1, 0, 8'h80);
        put(0, 1, col[7:0]); put(0, 1, col[15:8]);
        put(0, 1, row[7:0]); put(0, 1, row[15:8]);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = seed + 8'(i * 37);
            put(0, 0, b);
            if (c < PG) pg[c] = b;
            c++;
        end
    endtask

    function automatic logic [7:0] pg_sum();
        logic [7:0] s = 8'h00;
        for (int i = 0; i < PG; i++) s = s ^ pg[i];
        return s;
    endfunction

    task automatic wait_done(output int n);
        n = 0;
        while (!prog_done && n < 2000) begin rest(); n++; end
    endtask

    task automatic wait_rdy(output int n);
        n = 0;
        while (!rdy && n < 2000) begin rest(); n++; end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        int extra;
        fail_en = 1'b1; fail_row = 16'd13;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy == 1'b1, "R1 rdy after reset", rdy, 1);
        chk(io_out == 8'h00, "R1 io_out after reset", io_out, 0);
        chk(prog_done == 1'b0, "R1 prog_done after reset", prog_done, 0);
        put(1, 0, 8'h70); rest();
        chk(io_out == 8'h60, "R1 initial status", io_out, 8'h60);

        // full page with normal program
        load(16'd5, 16'd0, PG, 8'h11);
        put(1, 0, 8'h10); rest();
        chk(rdy == 1'b0, "R6 busy after page program", rdy, 0);
        wait_done(n);
        chk(n == XF + PR, "R6 busy span", n, XF + PR);
        chk(rdy == 1'b1, "R6 ready with completion", rdy, 1);
        chk(prog_row == 16'd5, "R2 row", prog_row, 5);
        chk(prog_sum == pg_sum(), "R2 page sum", prog_sum, pg_sum());
        rest();
        chk(prog_done == 1'b0, "R4 pulse one cycle", prog_done, 0);

        // load beyond page end
        load(16'd6, 16'd14, 4, 8'h5A);
        put(1, 0, 8'h10); rest();
        wait_done(n);
        chk(prog_sum == pg_sum(), "R2 columns past page dropped", prog_sum, pg_sum());

        // random column input
        load(16'd8, 16'd0, 4, 8'h33);
        put(1, 0, 8'h85); put(0, 1, 8'd10); put(0, 1, 8'd0);
        put(0, 0, 8'hC3); pg[10] = 8'hC3;
        put(0, 0, 8'h3C); pg[11] = 8'h3C;
        put(1, 0, 8'h10); rest();
        wait_done(n);
        chk(prog_sum == pg_sum(), "R3 column move keeps data", prog_sum, pg_sum());

        // cache chain in one block: rows 12, 13 (forced fail)
        load(16'd12, 16'd0, PG, 8'h21);
        put(1, 0, 8'h15); rest();
        wait_rdy(n);
        chk(n == XF, "R4 cache transfer span", n, XF);
        put(1, 0, 8'h70); rest();
        chk(io_out == 8'h40, "R7 cache ready, internal busy", io_out, 8'h40);
        load(16'd13, 16'd0, PG, 8'h42);
        put(1, 0, 8'h15); rest();
        chk(rdy == 1'b0, "R5 busy behind running program", rdy, 0);
        wait_done(n);
        chk(prog_row == 16'd12, "R5 first page finishes", prog_row, 12);
        wait_rdy(n);
        chk(n == XF, "R5 transfer after program end", n, XF);
        put(1, 0, 8'h70); rest();
        chk(io_out == 8'h40, "R8 previous page passed", io_out, 8'h40);
        wait_done(n);
        chk(io_out == 8'h61, "R8 current page failed", io_out, 8'h61);

        // normal program with commands sent while busy
        load(16'd14, 16'd0, PG, 8'h07);
        chk(io_out == 8'h00, "R11 status hidden after load", io_out, 0);
        put(1, 0, 8'h10); rest();
        put(1, 0, 8'h70); rest();
        chk(io_out == 8'h01, "R7 transfer pending", io_out, 8'h01);
        put(1, 0, 8'h80); put(0, 0, 8'hEE); rest();
        chk(io_out == 8'h42, "R9 busy commands ignored", io_out, 8'h42);
        wait_done(n);
        chk(prog_row == 16'd14, "R9 row unchanged", prog_row, 14);
        chk(prog_sum == pg_sum(), "R9 busy data ignored", prog_sum, pg_sum());
        chk(rdy == 1'b1, "R6 ready at completion", rdy, 1);
        put(1, 0, 8'h70); rest();
        chk(io_out == 8'h62, "R8 failed page moves to bit 1", io_out, 8'h62);

        // cross-block cache program is rejected
        load(16'd20, 16'd0, PG, 8'h55);
        put(1, 0, 8'h15); rest();
        wait_rdy(n);
        load(16'd30, 16'd0, PG, 8'h66);
        put(1, 0, 8'h15); rest();
        chk(rdy == 1'b1, "R10 other block stays ready", rdy, 1);
        wait_done(n);
        chk(prog_row == 16'd20, "R10 running page completes", prog_row, 20);
        extra = 0;
        for (int i = 0; i < XF + PR + 10; i++) begin
            rest();
            if (prog_done) extra++;
        end
        chk(extra == 0, "R10 no extra page programmed", extra, 0);

        put(1, 0, 8'h70); rest();
        chk(io_out == 8'h60, "R11 status shown", io_out, 8'h60);
        put(1, 0, 8'h80); rest();
        chk(io_out == 8'h00, "R11 status cleared by command", io_out, 0);
        repeat (4) rest();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule